// File: doc/BRIEF.md
# Self-Stepping Test-Array Scanner

This block walks on its own through an array of 2^p test elements, such as small ring oscillators. It turns on one element at a time and routes that element's output to a single shared output line, so that one slow external meter can record the whole array as one modulated stream. A fast free-running clock is slowed by a fixed integer ratio. The slowed ticks are grouped into a dwell window, and at the end of each window a p-bit address moves on by one. A one-hot decoder turns the address into the element enables. The outputs of all the elements are combined so that only the enabled element drives the shared line.

One address is kept empty on purpose. When the scan reaches it, no element is on and the shared line stays low for a full dwell window, which gives the external meter a fixed point to find in every pass. Arrays of 64 and 128 sites are supported (p of 6 or 7). In the 64-site case the array is laid out as four rows of sixteen and holds 63 live elements. The element outputs enter the block as ordinary logic inputs. A run input starts and stops the scan. Dropping run returns the block to a quiet state at address 0.

Top module: `osc_array_scanner`

## Requirements
- R1: `elem_en` never has more than one bit set. While `rst_n` and `run` are both high and `addr` is not the marker slot, exactly bit `addr` of `elem_en` is set.
- R2: While the scan is active and `addr` is not the marker slot, `scan_out` equals `elem_in[addr]`. The inputs of elements that are not enabled have no effect on `scan_out`.
- R3: When `addr` equals the marker slot (default 0), every bit of `elem_en` is 0 and `scan_out` is 0, whatever `elem_in` holds.
- R4: While `run` stays high, `addr` only ever steps by +1, and it wraps from 2^p−1 to 0.
- R5: Each address, including the first one after `run` rises, is held for exactly DIV_K × 2^DWELL_LOG clock cycles. With the defaults (3 × 4) this is 12 cycles.
- R6: While `run` is low, `elem_en` and `scan_out` are 0. The next clock edge clears `addr` and the divider, so a later rise of `run` starts a full dwell at address 0.
- R7: The reset `rst_n` is synchronous and active-low. While it is low, `elem_en` and `scan_out` are 0, and at each clock edge `addr` and all counters are cleared.
- R8: `dwell_len` reports the dwell window length, DIV_K × 2^DWELL_LOG, in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Scan enable; low holds the block idle at address 0 |
| elem_in | input | 2^ADDR_W | Outputs of the array elements |
| elem_en | output | 2^ADDR_W | One-hot element enables |
| addr | output | ADDR_W | Address currently selected |
| scan_out | output | 1 | Shared output line that follows the enabled element |
| dwell_len | output | 32 | Dwell window length in clock cycles |

## Verification
`elem_en` and `scan_out` are combinational. They respond to a change on `run`, `rst_n` or `elem_in` within the same cycle. `addr` is a register, so it changes at the edge that ends a dwell window: after the 12th consecutive edge with `run` high under the defaults, or at the first edge that sees `run` or `rst_n` low. The bench changes its inputs one time unit after each rising edge and compares every output at the following falling edge. Its model counts the edges that saw `run` and `rst_n` both high, so the expected address reflects every register transfer up to that edge and the gated outputs reflect the inputs as currently driven.

// File: rtl/scan_pkg.sv
// Package: shared helpers for the test-array scanner.
// Assumes: ratios and exponents are small positive integers.
package scan_pkg;

    // Width that holds a counter running from 0 to n-1 (at least 1 bit).
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Dwell window length in fast-clock cycles.
    function automatic int dwell_cycles(input int k, input int log2_ticks);
        return k * (1 << log2_ticks);
    endfunction

endpackage

// File: rtl/scan_divider.sv
// Module: scan_divider
// Emits a one-cycle tick every DIV_K fast-clock cycles while run is high.
// Assumes: DIV_K >= 1; run low or reset clears the phase to zero.
module scan_divider #(
    parameter int DIV_K = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    import scan_pkg::*;

    localparam int DIV_W = cnt_width(DIV_K);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_K - 1);

    logic [DIV_W-1:0] phase_q;

    // Tick on the last phase of the ratio, only while scanning.
    assign tick = run && (phase_q == DIV_LAST);

    // Phase counter: clears when idle, rolls over at the end of the ratio.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
        end else if (phase_q == DIV_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/scan_sequencer.sv
// Module: scan_sequencer
// Groups divider ticks into dwell windows of 2^DWELL_LOG ticks and steps
// the array address by one at the end of each window, wrapping at the top.
// Assumes: tick is a single-cycle pulse that is only high while run is high.
module scan_sequencer #(
    parameter int ADDR_W    = 6,
    parameter int DWELL_LOG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    output logic [ADDR_W-1:0] addr
);
    logic              win_end;
    logic [ADDR_W-1:0] addr_q;

    generate
        if (DWELL_LOG == 0) begin : g_single
            // Every tick closes a window.
            assign win_end = tick;
        end else begin : g_multi
            logic [DWELL_LOG-1:0] ticks_q;

            assign win_end = tick && (&ticks_q);

            // Tick counter inside the window; wraps naturally at 2^DWELL_LOG.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    ticks_q <= '0;
                end else if (tick) begin
                    ticks_q <= ticks_q + 1'b1;
                end
            end
        end
    endgenerate

    // Address register: clears when idle, steps by one per closed window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            addr_q <= '0;
        end else if (win_end) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/scan_decoder.sv
// Module: scan_decoder
// Turns the address into one-hot enables, gated by the active flag.
// The marker slot has no enable bit at all.
// Assumes: MARKER_SLOT lies inside 0 .. 2^ADDR_W-1.
module scan_decoder #(
    parameter int ADDR_W      = 6,
    parameter int MARKER_SLOT = 0
) (
    input  logic                 active,
    input  logic [ADDR_W-1:0]    addr,
    output logic [2**ADDR_W-1:0] en
);
    localparam int SITES = 2 ** ADDR_W;

    generate
        for (genvar i = 0; i < SITES; i++) begin : g_site
            if (i == MARKER_SLOT) begin : g_marker
                // Reserved location: never enabled.
                assign en[i] = 1'b0;
            end else begin : g_live
                // Live element: on when selected and scanning.
                assign en[i] = active && (addr == ADDR_W'(i));
            end
        end
    endgenerate

endmodule

// File: rtl/scan_outmux.sv
// Module: scan_outmux
// Combines the element outputs onto one line; a disabled element adds 0.
// Assumes: en is one-hot or all zero.
module scan_outmux #(
    parameter int SITES = 64
) (
    input  logic [SITES-1:0] en,
    input  logic [SITES-1:0] elem_in,
    output logic             y
);
    // AND each element with its enable, then OR the results together.
    assign y = |(en & elem_in);

endmodule

// File: rtl/osc_array_scanner.sv
// Module: osc_array_scanner (top)
// Scans 2^ADDR_W test elements one at a time: divider -> dwell/address
// sequencer -> one-hot decoder -> shared output line.
// Assumes: rst_n is synchronous; elem_in is sampled only through the mux.
module osc_array_scanner #(
    parameter int ADDR_W      = 6,
    parameter int DIV_K       = 3,
    parameter int DWELL_LOG   = 2,
    parameter int MARKER_SLOT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [2**ADDR_W-1:0] elem_in,
    output logic [2**ADDR_W-1:0] elem_en,
    output logic [ADDR_W-1:0]    addr,
    output logic                 scan_out,
    output logic [31:0]          dwell_len
);
    import scan_pkg::*;

    localparam int SITES = 2 ** ADDR_W;
    localparam int DWELL = dwell_cycles(DIV_K, DWELL_LOG);

    logic tick;
    logic active;

    // The scan counts as active only out of reset and while run is high.
    assign active    = rst_n && run;
    assign dwell_len = 32'(DWELL);

    scan_divider #(.DIV_K(DIV_K)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    scan_sequencer #(.ADDR_W(ADDR_W), .DWELL_LOG(DWELL_LOG)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .addr  (addr)
    );

    scan_decoder #(.ADDR_W(ADDR_W), .MARKER_SLOT(MARKER_SLOT)) u_dec (
        .active (active),
        .addr   (addr),
        .en     (elem_en)
    );

    scan_outmux #(.SITES(SITES)) u_mux (
        .en      (elem_en),
        .elem_in (elem_in),
        .y       (scan_out)
    );

endmodule

// File: rtl/scan_checker.sv
// Module: scan_checker
// Property checks on the scanner's ports, bound to every instance.
// Assumes: the same parameters as the scanner it is bound to.
module scan_checker #(
    parameter int ADDR_W      = 6,
    parameter int DIV_K       = 3,
    parameter int DWELL_LOG   = 2,
    parameter int MARKER_SLOT = 0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run,
    input logic [2**ADDR_W-1:0] elem_in,
    input logic [2**ADDR_W-1:0] elem_en,
    input logic [ADDR_W-1:0]    addr,
    input logic                 scan_out
);
    localparam int DWELL = DIV_K * (2 ** DWELL_LOG);
    localparam logic [ADDR_W-1:0] MARK = ADDR_W'(MARKER_SLOT);

    logic [ADDR_W-1:0] last_addr;
    logic              run_q;
    logic [31:0]       stay;

    // Track how many edges the address has stayed put while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr <= '0;
            run_q     <= 1'b0;
            stay      <= '0;
        end else begin
            last_addr <= addr;
            run_q     <= run;
            if (!run) begin
                stay <= '0;
            end else if (addr != last_addr) begin
                stay <= 32'd1;
            end else if (stay < 32'(DWELL + 1)) begin
                stay <= stay + 1'b1;
            end
        end
    end

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(elem_en));

    p_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && addr != MARK) |-> elem_en[addr]);

    p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && addr != MARK) |-> (scan_out == elem_in[addr]));

    p_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == MARK) |-> (elem_en == '0 && !scan_out));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_q && addr != last_addr) |-> (addr == ADDR_W'(last_addr + 1'b1)));

    p_dwell_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_q && addr != last_addr) |-> (stay == 32'(DWELL)));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |-> (elem_en == '0 && !scan_out));

    p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (addr == '0));

    p_reset_quiet_r7: assert property (@(posedge clk)
        (!rst_n) |-> (elem_en == '0 && !scan_out));

endmodule

bind osc_array_scanner scan_checker #(
    .ADDR_W      (ADDR_W),
    .DIV_K       (DIV_K),
    .DWELL_LOG   (DWELL_LOG),
    .MARKER_SLOT (MARKER_SLOT)
) u_scan_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .elem_in  (elem_in),
    .elem_en  (elem_en),
    .addr     (addr),
    .scan_out (scan_out)
);

// File: tb/tb_osc_array_scanner.sv
// Bench: a behavioural model counts active edges and predicts the address,
// the enables and the shared output; all three are compared every cycle.
module tb_osc_array_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int AW     = 6;
    localparam int N      = 2 ** AW;
    localparam int K      = 3;
    localparam int DL     = 2;
    localparam int MARKER = 0;
    localparam int D      = K * (2 ** DL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic [N-1:0]  elem_in = '0;
    logic [N-1:0]  elem_en;
    logic [AW-1:0] addr;
    logic          scan_out;
    logic [31:0]   dwell_len;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int edges = 0;
    int pat_mode = 0;
    bit done = 1'b0;

    osc_array_scanner #(.ADDR_W(AW), .DIV_K(K), .DWELL_LOG(DL), .MARKER_SLOT(MARKER)) dut (
        .clk (clk), .rst_n (rst_n), .run (run), .elem_in (elem_in),
        .elem_en (elem_en), .addr (addr), .scan_out (scan_out), .dwell_len (dwell_len)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model: count edges that saw an active scan; anything else restarts it.
    always @(posedge clk) begin
        edges <= edges + 1;
        if (!rst_n || !run) cyc <= 0;
        else cyc <= cyc + 1;
    end

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output at each falling edge against the model.
    always @(negedge clk) begin
        if (edges > 0 && !done) begin
            int ea;
            bit act_on;
            logic [N-1:0] ee;
            logic eo;
            ea = (cyc / D) % N;
            act_on = rst_n && run;
            ee = '0;
            eo = 1'b0;
            if (act_on && ea != MARKER) begin
                ee[ea] = 1'b1;
                eo = elem_in[ea];
            end
            check("R4/R5 address", longint'(addr), longint'(ea));
            check(ea == MARKER ? "R3 marker enables" : "R1/R6/R7 enables",
                  longint'(elem_en), longint'(ee));
            check(ea == MARKER ? "R3 marker output" : "R2/R6/R7 output",
                  longint'(scan_out), longint'(eo));
        end
    end

    // Element stimulus: all ones, then alternating, then random words.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            case (pat_mode)
                0: elem_in = '1;
                1: elem_in = {(N/2){2'b10}};
                default: elem_in = {$urandom, $urandom};
            endcase
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R7: reset state.
        wait_cycles(4);
        check("R7 reset addr", longint'(addr), 0);
        check("R7 reset enables", longint'(elem_en), 0);
        check("R8 dwell length", longint'(dwell_len), longint'(D));
        // R6: out of reset but idle.
        rst_n = 1'b1;
        wait_cycles(5);
        check("R6 idle output", longint'(scan_out), 0);
        // R4/R5/R2: two full passes with a wrap, varying patterns.
        run = 1'b1;
        wait_cycles(N * D / 2);
        pat_mode = 1;
        wait_cycles(N * D / 2);
        pat_mode = 2;
        wait_cycles(N * D + 40);
        // R6: stop mid-scan, then restart.
        run = 1'b0;
        wait_cycles(3);
        run = 1'b1;
        wait_cycles(D * 5 + 7);
        // R7: reset while running.
        rst_n = 1'b0;
        wait_cycles(2);
        rst_n = 1'b1;
        wait_cycles(N * D + 20);
        run = 1'b0;
        wait_cycles(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule